// File: doc/BRIEF.md
# Exclusive access reservation monitor

This block arbitrates load-exclusive, store-exclusive and plain store requests from several processor ports. It decides whether each conditional store may write memory. The port index identifies the processor. Each processor has two reservation mechanisms, and the shared attribute of the access picks which one applies:

- For shared memory, a tag entry holds a granule address.
- For non-shared memory, a single bit records that a reservation is outstanding.

A conditional store succeeds only while its mechanism still holds the reservation, and a success uses that reservation up.

Requests are granted one per cycle, lowest port first. A requester holds its request until it sees its grant bit. The grant, the memory write permit and the lock-out status are combinational from the granted request and the current reservation state. The state changes at the next clock edge.

Top module: `xmon`

## Requirements
- R1: A load-exclusive (op 2'b01) with the shared bit set records the granule address (address bits above GB, GB=2 by default) as the issuing port's tag. A store-exclusive (op 2'b10) from that port to the same granule then writes memory (`mem_wr`=1, `xfail`=0).
- R2: A new shared load-exclusive replaces the port's previous tag. A later store-exclusive to the old granule fails and one to the new granule succeeds.
- R3: A non-shared load-exclusive sets only the port's outstanding bit. A non-shared store-exclusive then succeeds whatever its address.
- R4: A non-shared store-exclusive with no outstanding bit does not write and reports `xfail`=1.
- R5: A shared store-exclusive whose granule is not tagged by the issuing port does not write and reports `xfail`=1.
- R6: A successful store-exclusive consumes the reservation that allowed it, so a repeat store-exclusive fails.
- R7: Any memory write (plain or exclusive) to a shared granule clears every other port's tag on that granule. Tags on other granules stay intact. Non-shared writes clear no tags.
- R8: `xfail` is 0 on success and 1 on lock-out, and only for store-exclusives. A plain store (op 2'b00) always writes with `xfail`=0. Op 2'b11 is granted but has no effect on memory or reservations.
- R9: Among valid requests, only the lowest-numbered port is granted in a cycle, and `gnt` is at most one-hot.
- R10: Reset clears all tags and outstanding bits, so store-exclusives issued after reset fail.
- R11: Address bits below GB are ignored when granules are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | N | Request valid, one per port |
| req_op | input | 2*N | Operation per port: 00 store, 01 load-exclusive, 10 store-exclusive, 11 none |
| req_addr | input | AW*N | Physical address per port |
| req_shr | input | N | Shared attribute per port |
| gnt | output | N | One-hot grant of the request serviced this cycle |
| mem_wr | output | 1 | Permit for the granted store to write memory |
| xfail | output | 1 | Store-exclusive locked out (1) or succeeded (0) |

## Verification
On every cycle, the embedded assertions check the following:
- the grant is one-hot with lowest-port priority;
- a lock-out never coincides with a write;
- a shared load-exclusive leaves its tag set;
- a successful store-exclusive leaves its reservation consumed.

Cross-port effects cannot be judged from one cycle and are shown only by the bench's scenarios:
- a competing store killing another port's tag while sparing other granules;
- tag replacement;
- address-independent non-shared success;
- granule masking;
- the wipe on reset.

A behavioural model compared every cycle under random contention backs these scenarios.

// File: rtl/xmon.sv
module xmon #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int GB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_vld,
  input  logic [2*N-1:0]  req_op,
  input  logic [AW*N-1:0] req_addr,
  input  logic [N-1:0]    req_shr,
  output logic [N-1:0]    gnt,
  output logic            mem_wr,
  output logic            xfail
);
  localparam int TW = AW - GB;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] OP_ST = 2'b00, OP_LX = 2'b01, OP_SX = 2'b10;

  logic [N-1:0]  lflag, gtag_v;
  logic [TW-1:0] gtag_a [N];

  logic          any;
  logic [IW-1:0] sel;

  always_comb begin
    gnt = '0;
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++)
      if (req_vld[i] && !any) begin
        gnt[i] = 1'b1;
        sel    = IW'(i);
        any    = 1'b1;
      end
  end

  logic [1:0]    op;
  logic [TW-1:0] ga;
  logic          sh, hit, ok, ldex, stex, pst;

  assign op   = req_op[sel*2 +: 2];
  assign ga   = req_addr[sel*AW+GB +: TW];
  assign sh   = req_shr[sel];
  assign hit  = gtag_v[sel] && (gtag_a[sel] == ga);
  assign ok   = sh ? hit : lflag[sel];
  assign ldex = any && op == OP_LX;
  assign stex = any && op == OP_SX;
  assign pst  = any && op == OP_ST;

  assign mem_wr = pst || (stex && ok);
  assign xfail  = stex && !ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lflag  <= '0;
      gtag_v <= '0;
      for (int i = 0; i < N; i++) gtag_a[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (any && sel == IW'(i)) begin
          if (ldex && sh) begin
            gtag_v[i] <= 1'b1;
            gtag_a[i] <= ga;
          end
          if (ldex && !sh) lflag[i] <= 1'b1;
          if (stex && ok && sh)  gtag_v[i] <= 1'b0;
          if (stex && ok && !sh) lflag[i]  <= 1'b0;
        end else if (mem_wr && sh && gtag_v[i] && gtag_a[i] == ga) begin
          gtag_v[i] <= 1'b0;
        end
      end
    end
  end

  p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_fail_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n) xfail |-> !mem_wr);

  for (genvar i = 0; i < N; i++) begin : g_chk
    localparam logic [N-1:0] LOWER = (N'(1) << i) - N'(1);
    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> ((req_vld & LOWER) == '0));
    p_ldex_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && req_op[2*i +: 2] == OP_LX && req_shr[i]) |=> gtag_v[i]);
    p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && req_op[2*i +: 2] == OP_SX && mem_wr)
        |=> ($past(req_shr[i]) ? !gtag_v[i] : !lflag[i]));
  end
endmodule

// File: tb/xmon_tb.sv
module xmon_tb;
  localparam int N = 4, AW = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_vld = '0, req_shr = '0;
  logic [2*N-1:0] req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [N-1:0] gnt;
  logic mem_wr, xfail;

  xmon #(.N(N), .AW(AW), .GB(2)) u_dut (.clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .req_op(req_op), .req_addr(req_addr), .req_shr(req_shr), .gnt(gnt), .mem_wr(mem_wr), .xfail(xfail));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R10";
  bit mflag [N];
  bit mv [N];
  int ma [N];
  logic [N-1:0] last_gnt = '0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    last_gnt = gnt;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mflag[i] = 0; mv[i] = 0; ma[i] = 0; end
      chk("R10", "gnt in reset", int'(gnt), 0);
    end else begin
      int g; int op; int ga; bit sh; bit ok; bit ew; bit ef;
      g = -1;
      for (int i = N-1; i >= 0; i--) if (req_vld[i]) g = i;
      ew = 0; ef = 0;
      if (g >= 0) begin
        op = int'(req_op[g*2 +: 2]);
        ga = int'(req_addr[g*AW +: AW] >> 2);
        sh = req_shr[g];
        ok = sh ? (mv[g] && ma[g] == ga) : mflag[g];
        ew = (op == 0) || (op == 2 && ok);
        ef = (op == 2) && !ok;
        if (op == 1) begin
          if (sh) begin mv[g] = 1; ma[g] = ga; end else mflag[g] = 1;
        end
        if (op == 2 && ok) begin
          if (sh) mv[g] = 0; else mflag[g] = 0;
        end
        if (ew && sh)
          for (int i = 0; i < N; i++) if (i != g && mv[i] && ma[i] == ga) mv[i] = 0;
      end
      chk(cur_req, "model gnt", int'(gnt), g >= 0 ? (1 << g) : 0);
      chk(cur_req, "model mem_wr", int'(mem_wr), int'(ew));
      chk(cur_req, "model xfail", int'(xfail), int'(ef));
    end
  end

  task automatic op1(int p, int op, int a, bit sh, bit ew, bit ef, string tag);
    @(posedge clk); #1;
    cur_req = tag;
    req_vld = '0; req_vld[p] = 1;
    req_op[p*2 +: 2] = 2'(op);
    req_addr[p*AW +: AW] = AW'(a);
    req_shr[p] = sh;
    @(negedge clk); #1;
    chk(tag, "gnt", int'(gnt), 1 << p);
    chk(tag, "mem_wr", int'(mem_wr), int'(ew));
    chk(tag, "xfail", int'(xfail), int'(ef));
    @(posedge clk); #1;
    req_vld = '0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R10", "idle mem_wr", int'(mem_wr), 0);
    op1(0, 2, 'h100, 1, 0, 1, "R5");
    op1(0, 2, 'h100, 0, 0, 1, "R4");
    op1(0, 1, 'h100, 1, 0, 0, "R1");
    op1(0, 2, 'h102, 1, 1, 0, "R11");
    op1(0, 2, 'h100, 1, 0, 1, "R6");
    op1(1, 1, 'h200, 1, 0, 0, "R2");
    op1(1, 1, 'h300, 1, 0, 0, "R2");
    op1(1, 2, 'h200, 1, 0, 1, "R2");
    op1(1, 2, 'h300, 1, 1, 0, "R2");
    op1(2, 1, 'h40, 0, 0, 0, "R3");
    op1(2, 2, 'h9990, 0, 1, 0, "R3");
    op1(2, 2, 'h40, 0, 0, 1, "R6");
    op1(0, 1, 'h500, 1, 0, 0, "R7");
    op1(1, 1, 'h500, 1, 0, 0, "R7");
    op1(2, 1, 'h600, 1, 0, 0, "R7");
    op1(3, 0, 'h501, 1, 1, 0, "R8");
    op1(0, 2, 'h500, 1, 0, 1, "R7");
    op1(1, 2, 'h500, 1, 0, 1, "R7");
    op1(2, 2, 'h600, 1, 1, 0, "R7");
    op1(0, 1, 'h700, 1, 0, 0, "R7");
    op1(1, 1, 'h700, 1, 0, 0, "R7");
    op1(1, 2, 'h700, 1, 1, 0, "R7");
    op1(0, 2, 'h700, 1, 0, 1, "R7");
    op1(3, 1, 'h800, 1, 0, 0, "R7");
    op1(0, 0, 'h800, 0, 1, 0, "R7");
    op1(3, 2, 'h800, 1, 1, 0, "R7");
    op1(0, 1, 'h900, 1, 0, 0, "R8");
    op1(0, 3, 'h900, 1, 0, 0, "R8");
    op1(0, 2, 'h900, 1, 1, 0, "R8");
    // R9: ports 1 and 3 contend
    @(posedge clk); #1;
    cur_req = "R9";
    req_vld = 4'b1010; req_op = '0; req_shr = '0;
    @(negedge clk); #1;
    chk("R9", "first grant", int'(gnt), 'b0010);
    @(posedge clk); #1;
    req_vld = 4'b1000;
    @(negedge clk); #1;
    chk("R9", "second grant", int'(gnt), 'b1000);
    @(posedge clk); #1;
    req_vld = '0;
    // R10
    op1(0, 1, 'hA00, 1, 0, 0, "R10");
    op1(1, 1, 'h0, 0, 0, 0, "R10");
    #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    op1(0, 2, 'hA00, 1, 0, 1, "R10");
    op1(1, 2, 'h0, 0, 0, 1, "R10");
    // random contention against the model
    cur_req = "R9";
    for (int c = 0; c < 400; c++) begin
      @(posedge clk); #1;
      for (int p = 0; p < N; p++) begin
        if (last_gnt[p] || !req_vld[p]) begin
          req_vld[p] = ($urandom % 3) != 0;
          req_op[p*2 +: 2] = 2'($urandom % 4);
          req_addr[p*AW +: AW] = AW'('h100 + 4 * ($urandom % 3) + ($urandom % 4));
          req_shr[p] = ($urandom % 4) != 0;
        end
      end
      last_gnt = '0;
    end
    @(posedge clk); #1 req_vld = '0;
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule